// File: doc/BRIEF.md
# Peer Doorbell Interrupt Register Block

This block sits on a simple word-addressed register bus and lets one node that shares a memory region with its peers ring a doorbell at another node, and take doorbells rung at it. Software sees four 32-bit registers in a 1 KB window: an interrupt enable mask, an interrupt flag, a read-only node identity and a doorbell. A write to the doorbell is turned into an outgoing request that carries a destination node number and a vector. The fabric that carries that request to the peer lies outside the block.

Doorbell events arriving from peers are handled in one of two ways, chosen by the `msg_mode` input. In pin mode an event sets the interrupt flag, and a level interrupt line is driven from the flag and the mask. In message mode the low 16 bits of the event select one of `MAX_VEC` message-interrupt outputs, which is pulsed for one cycle, and the flag is left alone. A vector outside the configured range is discarded and latches an error bit. The identity register reads all ones until the node is ready.

Neither stream port has back-pressure. The outgoing doorbell is a one-cycle `db_valid` pulse, and the receiver must take it in that cycle. Incoming events are accepted in every cycle in which `evt_valid` is high.

Top module: `peer_doorbell`

## Requirements
- R1: After reset the mask and the flag read as zero, and `irq_pin`, `msg_pulse`, `vec_err`, `db_valid` and `rd_valid` are all low.
- R2: The mask register at byte offset 0 stores all 32 written bits and reads them back unchanged.
- R3: In pin mode (`msg_mode`=0), an incoming event sets the flag register at offset 4 to the value 1, whatever its vector, and pulses no `msg_pulse` bit.
- R4: `irq_pin` is high exactly when mask bit 0 and the flag are both 1. Mask bits 31:1 have no effect on it.
- R5: A read of offset 4 returns the flag and clears it in the same access. If a pin-mode event arrives in that same cycle, the flag stays at 1. Writes to offset 4 have no effect.
- R6: Offset 8 reads 32'hFFFF_FFFF while `node_ready` is low, and {16'b0, `node_id`} while it is high. Writes to offset 8 are ignored.
- R7: A write to offset 12 raises `db_valid` for exactly the one following cycle, with `db_dest` = wdata[31:16] and `db_vector` = wdata[15:0]. Offset 12 reads as zero.
- R8: In message mode (`msg_mode`=1), an event with vector v < `MAX_VEC` drives `msg_pulse` to one-hot bit v for the following cycle only, and leaves the flag unchanged.
- R9: In message mode, an event with vector v >= `MAX_VEC` pulses no `msg_pulse` bit and sets `vec_err` from the next cycle on. `vec_err` then stays high until reset.
- R10: The word index is `bus_addr`[9:2], and bits [1:0] are ignored. Reads of any word other than 0 to 3 return zero, and writes to those words change nothing.
- R11: Every read request raises `rd_valid` in the following cycle, with the data on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address within the 1 KB window |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| node_ready | input | 1 | Node identity is valid |
| node_id | input | 16 | This node's identity number |
| msg_mode | input | 1 | 0 = pin interrupt, 1 = message interrupt |
| evt_valid | input | 1 | Incoming doorbell event from a peer |
| evt_vector | input | 16 | Vector of the incoming event |
| irq_pin | output | 1 | Level interrupt line |
| msg_pulse | output | MAX_VEC | One-hot message-interrupt pulses |
| vec_err | output | 1 | Sticky out-of-range vector flag |
| db_valid | output | 1 | Outgoing doorbell request, one-cycle pulse |
| db_dest | output | 16 | Destination node of the outgoing doorbell |
| db_vector | output | 16 | Vector of the outgoing doorbell |

## Verification
The properties assume that `msg_mode` is steady across each event and the cycle after it, because they relate an event to its effect one cycle later. They also assume that `bus_sel` and `evt_valid` are never unknown after reset. The stimulus drives every input on the falling edge and holds `msg_mode` fixed for the whole of each operation. It draws vectors both below and above `MAX_VEC`, and addresses both inside and outside the mapped words. Read and event operations are kept apart, except for one directed case that puts a flag read and a pin event in the same cycle.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  localparam int REG_W   = 32;
  localparam int FIELD_W = 16;
  localparam int NREGS   = 4;

  typedef enum logic [1:0] {
    RS_MASK  = 2'd0,
    RS_FLAG  = 2'd1,
    RS_IDENT = 2'd2,
    RS_BELL  = 2'd3
  } reg_slot_e;

  typedef struct packed {
    logic [FIELD_W-1:0] dest;
    logic [FIELD_W-1:0] vec;
  } bell_word_t;
endpackage

// File: rtl/pdb_decode.sv
module pdb_decode
  import pdb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  output logic [NREGS-1:0] wr_hit,
  output logic [NREGS-1:0] rd_hit,
  output logic          rd_req
);
  localparam int WW = AW - 2;

  logic [WW-1:0] word_idx;
  assign word_idx = bus_addr[AW-1:2];
  assign rd_req   = bus_sel && !bus_we;

  for (genvar i = 0; i < NREGS; i++) begin : g_hit
    logic sel_i;
    assign sel_i     = bus_sel && (word_idx == WW'(i));
    assign wr_hit[i] = sel_i && bus_we;
    assign rd_hit[i] = sel_i && !bus_we;
  end
endmodule

// File: rtl/pdb_evt.sv
module pdb_evt
  import pdb_pkg::*;
#(
  parameter int MAX_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_mode,
  input  logic               evt_valid,
  input  logic [FIELD_W-1:0] evt_vector,
  output logic               flag_set,
  output logic [MAX_VEC-1:0] msg_pulse,
  output logic               vec_err
);
  localparam logic [FIELD_W-1:0] LIMIT = FIELD_W'(MAX_VEC);

  logic               msg_evt;
  logic               bad_vec;
  logic [MAX_VEC-1:0] pulse_d;

  assign msg_evt  = evt_valid && msg_mode;
  assign flag_set = evt_valid && !msg_mode;
  assign bad_vec  = msg_evt && (evt_vector >= LIMIT);

  for (genvar v = 0; v < MAX_VEC; v++) begin : g_vec
    assign pulse_d[v] = msg_evt && (evt_vector == FIELD_W'(v));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_pulse <= '0;
      vec_err   <= 1'b0;
    end else begin
      msg_pulse <= pulse_d;
      if (bad_vec) vec_err <= 1'b1;
    end
  end
endmodule

// File: rtl/pdb_regs.sv
module pdb_regs
  import pdb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREGS-1:0]   wr_hit,
  input  logic [NREGS-1:0]   rd_hit,
  input  logic               rd_req,
  input  logic [REG_W-1:0]   wdata,
  input  logic               flag_set,
  input  logic               node_ready,
  input  logic [FIELD_W-1:0] node_id,
  output logic               mask_bit0,
  output logic               flag_q,
  output logic               rd_valid,
  output logic [REG_W-1:0]   rd_data
);
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] ident_val;
  logic [REG_W-1:0] rd_mux;

  assign mask_bit0 = mask_q[0];
  assign ident_val = node_ready ? {{(REG_W-FIELD_W){1'b0}}, node_id} : '1;

  always_comb begin
    rd_mux = '0;
    if (rd_hit[RS_MASK])  rd_mux = mask_q;
    if (rd_hit[RS_FLAG])  rd_mux = {{(REG_W-1){1'b0}}, flag_q};
    if (rd_hit[RS_IDENT]) rd_mux = ident_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      flag_q   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (wr_hit[RS_MASK]) mask_q <= wdata;
      if (flag_set)             flag_q <= 1'b1;
      else if (rd_hit[RS_FLAG]) flag_q <= 1'b0;
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/pdb_tx.sv
module pdb_tx
  import pdb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bell_wr,
  input  logic [REG_W-1:0]   wdata,
  output logic               db_valid,
  output logic [FIELD_W-1:0] db_dest,
  output logic [FIELD_W-1:0] db_vector
);
  bell_word_t word_in;
  assign word_in = bell_word_t'(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_valid  <= 1'b0;
      db_dest   <= '0;
      db_vector <= '0;
    end else begin
      db_valid <= bell_wr;
      if (bell_wr) begin
        db_dest   <= word_in.dest;
        db_vector <= word_in.vec;
      end
    end
  end
endmodule

// File: rtl/peer_doorbell.sv
module peer_doorbell
  import pdb_pkg::*;
#(
  parameter int AW      = 10,
  parameter int MAX_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic               rd_valid,
  output logic [REG_W-1:0]   rd_data,
  input  logic               node_ready,
  input  logic [FIELD_W-1:0] node_id,
  input  logic               msg_mode,
  input  logic               evt_valid,
  input  logic [FIELD_W-1:0] evt_vector,
  output logic               irq_pin,
  output logic [MAX_VEC-1:0] msg_pulse,
  output logic               vec_err,
  output logic               db_valid,
  output logic [FIELD_W-1:0] db_dest,
  output logic [FIELD_W-1:0] db_vector
);
  logic [NREGS-1:0] wr_hit;
  logic [NREGS-1:0] rd_hit;
  logic             rd_req;
  logic             flag_set;
  logic             mask_bit0;
  logic             flag_q;

  pdb_decode #(.AW(AW)) u_dec (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wr_hit   (wr_hit),
    .rd_hit   (rd_hit),
    .rd_req   (rd_req)
  );

  pdb_evt #(.MAX_VEC(MAX_VEC)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_mode   (msg_mode),
    .evt_valid  (evt_valid),
    .evt_vector (evt_vector),
    .flag_set   (flag_set),
    .msg_pulse  (msg_pulse),
    .vec_err    (vec_err)
  );

  pdb_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit     (wr_hit),
    .rd_hit     (rd_hit),
    .rd_req     (rd_req),
    .wdata      (bus_wdata),
    .flag_set   (flag_set),
    .node_ready (node_ready),
    .node_id    (node_id),
    .mask_bit0  (mask_bit0),
    .flag_q     (flag_q),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  pdb_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bell_wr   (wr_hit[RS_BELL]),
    .wdata     (bus_wdata),
    .db_valid  (db_valid),
    .db_dest   (db_dest),
    .db_vector (db_vector)
  );

  assign irq_pin = mask_bit0 & flag_q;
endmodule

// File: rtl/pdb_checker.sv
module pdb_checker #(
  parameter int AW      = 10,
  parameter int MAX_VEC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_we,
  input logic [AW-1:0]      bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               rd_valid,
  input logic [31:0]        rd_data,
  input logic               node_ready,
  input logic               msg_mode,
  input logic               evt_valid,
  input logic [15:0]        evt_vector,
  input logic [MAX_VEC-1:0] msg_pulse,
  input logic               vec_err,
  input logic               db_valid,
  input logic [15:0]        db_dest,
  input logic [15:0]        db_vector,
  input logic               flag_q
);
  localparam logic [15:0] LIMIT = 16'(MAX_VEC);

  logic rd_any, rd_flag, rd_ident, rd_unmapped, wr_bell, pin_evt, msg_ok, msg_bad;
  assign rd_any      = bus_sel && !bus_we;
  assign rd_flag     = rd_any && (bus_addr[AW-1:2] == (AW-2)'(1));
  assign rd_ident    = rd_any && (bus_addr[AW-1:2] == (AW-2)'(2));
  assign rd_unmapped = rd_any && (bus_addr[AW-1:4] != '0);
  assign wr_bell     = bus_sel && bus_we && (bus_addr[AW-1:2] == (AW-2)'(3));
  assign pin_evt     = evt_valid && !msg_mode;
  assign msg_ok      = evt_valid && msg_mode && (evt_vector < LIMIT);
  assign msg_bad     = evt_valid && msg_mode && (evt_vector >= LIMIT);

  a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    pin_evt |=> (flag_q && msg_pulse == '0));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flag && !pin_evt) |=> !flag_q);

  a_r6_ident_unready: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ident && !node_ready) |=> (rd_data == 32'hFFFF_FFFF));

  a_r7_bell_out: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bell |=> (db_valid && db_dest == $past(bus_wdata[31:16])
                 && db_vector == $past(bus_wdata[15:0])));

  a_r7_bell_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_bell |=> !db_valid);

  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(msg_pulse));

  a_r8_pulse_bit: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ok |=> (msg_pulse == (MAX_VEC)'(1) << $past(evt_vector)));

  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    msg_bad |=> (vec_err && msg_pulse == '0));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    vec_err |=> vec_err);

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> (rd_data == '0));

  a_r11_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> rd_valid);
endmodule

bind peer_doorbell pdb_checker #(.AW(AW), .MAX_VEC(MAX_VEC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .node_ready (node_ready),
  .msg_mode   (msg_mode),
  .evt_valid  (evt_valid),
  .evt_vector (evt_vector),
  .msg_pulse  (msg_pulse),
  .vec_err    (vec_err),
  .db_valid   (db_valid),
  .db_dest    (db_dest),
  .db_vector  (db_vector),
  .flag_q     (flag_q)
);

// File: tb/peer_doorbell_test.sv
module peer_doorbell_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int MAX_VEC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic node_ready = 0;
  logic [15:0] node_id = '0;
  logic msg_mode = 0, evt_valid = 0;
  logic [15:0] evt_vector = '0;
  logic irq_pin, vec_err, db_valid;
  logic [MAX_VEC-1:0] msg_pulse;
  logic [15:0] db_dest, db_vector;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_mask = '0;
  logic m_flag = 0, m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  peer_doorbell #(.AW(AW), .MAX_VEC(MAX_VEC)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    logic [AW-3:0] w = a[AW-1:2];
    case (w)
      0: return m_mask;
      1: return {31'b0, m_flag};
      2: return node_ready ? {16'b0, node_id} : 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check_irq();
    chk("R4 irq_pin", {31'b0, irq_pin}, {31'b0, m_mask[0] & m_flag});
    chk("R9 vec_err", {31'b0, vec_err}, {31'b0, m_err});
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    if (a[AW-1:2] == 0) m_mask = d;
    if (a[AW-1:2] == 3) begin
      chk("R7 db_valid", {31'b0, db_valid}, 32'd1);
      chk("R7 db fields", {db_dest, db_vector}, d);
      @(negedge clk);
      chk("R7 db single", {31'b0, db_valid}, 32'd0);
    end else begin
      chk("R7 db idle", {31'b0, db_valid}, 32'd0);
    end
    check_irq();
  endtask

  task automatic bus_rd(input string req, input logic [AW-1:0] a);
    logic [31:0] exp = exp_read(a);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk("R11 rd_valid", {31'b0, rd_valid}, 32'd1);
    chk(req, rd_data, exp);
    if (a[AW-1:2] == 1) m_flag = 0;
    check_irq();
  endtask

  task automatic send_evt(input logic mode, input logic [15:0] v);
    logic [MAX_VEC-1:0] exp_p = '0;
    @(negedge clk);
    msg_mode = mode; evt_valid = 1; evt_vector = v;
    @(negedge clk);
    evt_valid = 0;
    if (!mode) m_flag = 1;
    else if (v < MAX_VEC) exp_p[v] = 1'b1;
    else m_err = 1;
    chk(mode ? (v < MAX_VEC ? "R8 pulse" : "R9 drop") : "R3 no pulse",
        32'(msg_pulse), 32'(exp_p));
    check_irq();
    @(negedge clk);
    chk("R8 pulse ends", 32'(msg_pulse), 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq_pin}, 0);
    chk("R1 pulse", 32'(msg_pulse), 0);
    chk("R1 err", {31'b0, vec_err}, 0);
    chk("R1 db_valid", {31'b0, db_valid}, 0);
    chk("R1 rd_valid", {31'b0, rd_valid}, 0);
    bus_rd("R1 mask", 10'h000);
    bus_rd("R1 flag", 10'h004);
    bus_rd("R6 ident unready", 10'h008);

    // R2 / R4: upper mask bits do nothing
    bus_wr(10'h000, 32'hFFFF_FFFE);
    bus_rd("R2 mask readback", 10'h000);
    send_evt(1'b0, 16'hBEEF);            // R3 flag set, irq stays low
    bus_wr(10'h000, 32'h0000_0001);      // R4 irq rises
    bus_wr(10'h004, 32'h0);              // R5 write to flag ignored
    bus_rd("R5 flag read", 10'h004);
    bus_rd("R5 flag cleared", 10'h004);

    // R5 simultaneous read and pin event
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = 10'h004;
    msg_mode = 0; evt_valid = 1; evt_vector = 16'h0;
    @(negedge clk);
    bus_sel = 0; evt_valid = 0;
    chk("R5 same-cycle read value", rd_data, 32'h0);
    m_flag = 1;
    check_irq();
    bus_rd("R5 event wins", 10'h004);

    // R6 identity
    node_id = 16'h0005; node_ready = 1;
    bus_rd("R6 ident ready", 10'h008);
    bus_wr(10'h008, 32'h1234_5678);
    bus_rd("R6 ident write ignored", 10'h008);

    // R7 doorbell
    bus_wr(10'h00C, 32'hABCD_0003);
    bus_rd("R7 bell reads zero", 10'h00C);

    // R8 / R9 message mode edges
    send_evt(1'b1, 16'd7);
    send_evt(1'b1, 16'd0);
    send_evt(1'b1, 16'd8);
    bus_rd("R8 flag untouched", 10'h004);

    // R10 unmapped and low address bits
    bus_wr(10'h3FC, 32'hDEAD_BEEF);
    bus_rd("R10 mask after unmapped write", 10'h000);
    bus_rd("R10 unmapped read", 10'h3FC);
    bus_rd("R10 unmapped read low", 10'h010);
    bus_rd("R10 low bits ignored", 10'h003);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 8;
      int r  = $urandom % 10;
      logic [AW-3:0] w = (r < 8) ? (AW-2)'(r % 5) : (AW-2)'($urandom);
      logic [AW-1:0] a = {w, 2'($urandom)};
      if (op < 2) bus_wr(a, $urandom);
      else if (op < 5) bus_rd("R10 random read", a);
      else if (op < 7) send_evt(1'($urandom), 16'($urandom % (MAX_VEC + 4)));
      else begin
        node_ready = 1'($urandom);
        node_id = 16'($urandom);
        bus_rd("R6 random ident", 10'h008);
      end
    end

    finish_run();
  end
endmodule